// File: doc/BRIEF.md
# Two-wire Sensor Register Slave

This block is the serial-bus front end of a two-channel light sensor. It listens on an oversampled two-wire bus (clock and data lines sampled by the system clock), recognises its own 7-bit address, and turns bus frames into simple register-file strobes. Its 7-bit address is picked by a three-level strap: tied low, left floating, or tied high. The strap reaches the block as a 2-bit code.

Every exchange is built around a command byte. After an address frame with the write direction, the first byte loads a 4-bit register pointer. Any further bytes are written to the register under the pointer, and the pointer then advances. An address frame with the read direction returns the byte under the pointer, and the pointer advances again. This covers the short "send byte" and "receive byte" forms. It also covers multi-byte writes, and reads that reach the pointer through a repeated START. The block pulls the data line low through an open-drain enable. It also drives an open-drain enable for the sensor's interrupt pin.

Top module: `i2c_sensor_slave`

## Requirements
- R1: The own address is 0101001 for strap code 00, 0111001 for code 01, 1001001 for code 10, and 0111001 for code 11.
- R2: An address byte is the 7 address bits sent MSB first, followed by a direction bit (0 = write, 1 = read). When the address matches, the slave pulls SDA low during the 9th clock.
- R3: An address that does not match gets no ACK. After it, no data byte is acknowledged and no write or read strobe occurs until the next START or STOP.
- R4: The first byte after a matching write address is the command byte. It is acknowledged, and its low 4 bits load the register pointer. The upper 4 bits have no effect.
- R5: Each later written byte is acknowledged. It produces a one-cycle `reg_wr_en` carrying the pointer and the byte, and the pointer then increments, wrapping from 15 to 0.
- R6: After a matching read address, the slave gives a one-cycle `rd_req` with `rd_addr` equal to the pointer, and the pointer then increments. It samples `rd_data` in the same cycle. The byte is shifted out MSB first. A master ACK requests the next byte in the same way.
- R7: After a master NACK, the slave releases SDA and issues no further `rd_req` until a new address frame.
- R8: The slave only starts pulling SDA low while SCL is low.
- R9: A START or repeated START (SDA falls while SCL is high) restarts address reception. A STOP (SDA rises while SCL is high) returns the slave to idle. Both release SDA at once.
- R10: `int_oe` equals `irq_src` delayed by one clock.
- R11: After reset, `sda_oe`, `int_oe`, `reg_wr_en` and `rd_req` are 0 and the register pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_code | input | 2 | Address strap: 00 low, 01 float, 10 high, 11 float |
| irq_src | input | 1 | Interrupt request from sensor core |
| int_oe | output | 1 | 1 pulls the interrupt pin low |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 4 | Register index for the write |
| reg_wr_data | output | 8 | Byte to write |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 4 | Register index to read |
| rd_data | input | 8 | Read byte, sampled while `rd_req` is high |

## Verification
An SCL or SDA change at the pins passes two synchronizer stages and one edge register. So a pull-down of SDA, or a write or read strobe, appears about four clocks after the SCL edge that causes it, and `int_oe` follows `irq_src` after one clock. The bench holds every bus level for ten clocks before the next transition. It samples the ACK and read bits at the end of the SCL-high phase, and counts strobes over a whole frame before comparing, so the few cycles of pipeline never fall inside a sample window. Strobe addresses and data are compared with a pointer model that the bench keeps from the command bytes it sends.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    M_IDLE,
    M_ADDR,
    M_CMD,
    M_WDATA,
    M_RDATA,
    M_SKIP
  } mode_t;

  function automatic logic [6:0] strap_to_addr(input logic [1:0] code);
    case (code)
      2'b00:   strap_to_addr = 7'b0101001;
      2'b10:   strap_to_addr = 7'b1001001;
      default: strap_to_addr = 7'b0111001;
    endcase
  endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '1;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cs_line_events.sv
module i2cs_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_lvl   = scl_s;
  assign sda_lvl   = sda_s;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
endmodule

// File: rtl/i2cs_xfer_fsm.sv
module i2cs_xfer_fsm
  import i2cs_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic [6:0]       own_addr,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic             reg_wr_en,
  output logic [PTR_W-1:0] reg_wr_addr,
  output logic [7:0]       reg_wr_data,
  output logic             rd_req,
  output logic [PTR_W-1:0] rd_addr
);
  localparam logic [3:0] ACK_SLOT = 4'd8;
  localparam logic [3:0] LAST_BIT = 4'd7;

  mode_t            mode, next_mode;
  logic [3:0]       bit_cnt;
  logic [6:0]       rx_sh;
  logic [7:0]       tx_sh;
  logic             ack_q;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       rx_byte;

  assign rx_byte = {rx_sh, sda_lvl};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode        <= M_IDLE;
      next_mode   <= M_IDLE;
      bit_cnt     <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      ack_q       <= 1'b0;
      ptr         <= '0;
      sda_oe      <= 1'b0;
      reg_wr_en   <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_data <= '0;
      rd_req      <= 1'b0;
      rd_addr     <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      rd_req    <= 1'b0;
      if (rd_req) tx_sh <= rd_data;

      if (start_evt) begin
        mode    <= M_ADDR;
        bit_cnt <= '0;
        ack_q   <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        mode    <= M_IDLE;
        bit_cnt <= '0;
        ack_q   <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (mode != M_IDLE && mode != M_SKIP) begin
        if (scl_rise) begin
          if (bit_cnt != ACK_SLOT) begin
            rx_sh   <= rx_byte[6:0];
            bit_cnt <= bit_cnt + 4'd1;
            if (bit_cnt == LAST_BIT) begin
              case (mode)
                M_ADDR: begin
                  if (rx_byte[7:1] == own_addr) begin
                    ack_q <= 1'b1;
                    if (rx_byte[0]) begin
                      next_mode <= M_RDATA;
                      rd_req    <= 1'b1;
                      rd_addr   <= ptr;
                      ptr       <= ptr + 1'b1;
                    end else begin
                      next_mode <= M_CMD;
                    end
                  end else begin
                    ack_q     <= 1'b0;
                    next_mode <= M_SKIP;
                  end
                end
                M_CMD: begin
                  ptr       <= rx_byte[PTR_W-1:0];
                  ack_q     <= 1'b1;
                  next_mode <= M_WDATA;
                end
                M_WDATA: begin
                  reg_wr_en   <= 1'b1;
                  reg_wr_addr <= ptr;
                  reg_wr_data <= rx_byte;
                  ptr         <= ptr + 1'b1;
                  ack_q       <= 1'b1;
                  next_mode   <= M_WDATA;
                end
                default: begin
                  ack_q     <= 1'b0;
                  next_mode <= M_RDATA;
                end
              endcase
            end
          end else begin
            bit_cnt <= '0;
            if (mode == M_RDATA) begin
              if (!sda_lvl) begin
                rd_req  <= 1'b1;
                rd_addr <= ptr;
                ptr     <= ptr + 1'b1;
              end else begin
                mode <= M_SKIP;
              end
            end else begin
              mode <= next_mode;
            end
          end
        end else if (scl_fall) begin
          if (bit_cnt == ACK_SLOT) begin
            sda_oe <= ack_q;
          end else if (mode == M_RDATA) begin
            sda_oe <= ~tx_sh[7];
            tx_sh  <= {tx_sh[6:0], 1'b0};
          end else begin
            sda_oe <= 1'b0;
          end
        end
      end else if (scl_fall) begin
        sda_oe <= 1'b0;
      end
    end
  end

  AST_PULL_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_lvl)); // R8
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en); // R5
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req); // R6
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (stop_evt || start_evt) |=> !sda_oe); // R9
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (mode == M_SKIP) |-> (!reg_wr_en && !rd_req && !$rose(sda_oe))); // R3
endmodule

// File: rtl/i2c_sensor_slave.sv
module i2c_sensor_slave
  import i2cs_pkg::*;
#(
  parameter int PTR_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  input  logic [1:0]       strap_code,
  input  logic             irq_src,
  output logic             int_oe,
  output logic             reg_wr_en,
  output logic [PTR_W-1:0] reg_wr_addr,
  output logic [7:0]       reg_wr_data,
  output logic             rd_req,
  output logic [PTR_W-1:0] rd_addr,
  input  logic [7:0]       rd_data
);
  logic [1:0] line_s;
  logic       scl_lvl, sda_lvl, start_evt, stop_evt, scl_rise, scl_fall;
  logic [6:0] own_addr;

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(line_s)
  );

  i2cs_line_events u_ev (
    .clk(clk), .rst(rst), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .start_evt(start_evt),
    .stop_evt(stop_evt), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      own_addr <= strap_to_addr(2'b01);
      int_oe   <= 1'b0;
    end else begin
      own_addr <= strap_to_addr(strap_code);
      int_oe   <= irq_src;
    end
  end

  i2cs_xfer_fsm #(.PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .start_evt(start_evt), .stop_evt(stop_evt), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .own_addr(own_addr), .rd_data(rd_data),
    .sda_oe(sda_oe), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .rd_req(rd_req), .rd_addr(rd_addr)
  );

  AST_INT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (int_oe == $past(irq_src))); // R10
endmodule

// File: tb/i2c_sensor_slave_test.sv
module i2c_sensor_slave_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic       irq = 1'b0;
  logic       sda_oe, int_oe, reg_wr_en, rd_req;
  logic [3:0] reg_wr_addr, rd_addr;
  logic [7:0] reg_wr_data, rd_data;
  logic [7:0] regs [16];
  wire        sda_line = sda_m & ~sda_oe;

  assign rd_data = regs[rd_addr];

  i2c_sensor_slave uut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap_code(strap), .irq_src(irq), .int_oe(int_oe),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int nchk = 0, nfail = 0, wn = 0, rn = 0;
  logic [3:0] wa [64];
  logic [7:0] wd [64];
  logic [3:0] ra [64];
  logic [3:0] exp_ptr = 4'd0;

  always @(negedge clk) begin
    if (!rst) begin
      if (reg_wr_en) begin
        wa[wn % 64] = reg_wr_addr; wd[wn % 64] = reg_wr_data;
        regs[reg_wr_addr] = reg_wr_data; wn++;
      end
      if (rd_req) begin ra[rn % 64] = rd_addr; rn++; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] addr_of(input logic [1:0] c);
    if (c == 2'b00) return 7'h29;
    if (c == 2'b10) return 7'h49;
    return 7'h39;
  endfunction

  task automatic q(); repeat (10) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); scl_m = 1'b0;
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_line; scl_m = 1'b0;
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = {b[6:0], sda_line}; scl_m = 1'b0;
    end
    sda_m = nack; q(); scl_m = 1'b1; q(); scl_m = 1'b0; sda_m = 1'b1;
  endtask

  // Write: START, addr+W, command, n data bytes, STOP
  task automatic do_write(input logic [6:0] a, input logic [7:0] cmd, input int n);
    logic ack; logic [7:0] d; int w0; logic [3:0] ea [8]; logic [7:0] ed [8];
    w0 = wn;
    bus_start();
    wbyte({a, 1'b0}, ack); chk("R2 address ack", ack, 1);
    wbyte(cmd, ack);       chk("R4 command ack", ack, 1);
    exp_ptr = cmd[3:0];
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      wbyte(d, ack); chk("R5 data ack", ack, 1);
      ea[k] = exp_ptr; ed[k] = d; exp_ptr = exp_ptr + 4'd1;
    end
    bus_stop(); q();
    chk("R5 write count", wn - w0, n);
    for (int k = 0; k < n; k++) begin
      chk("R5 write addr", wa[(w0 + k) % 64], ea[k]);
      chk("R5 write data", wd[(w0 + k) % 64], ed[k]);
    end
    chk("R9 released after stop", sda_oe, 0);
  endtask

  // Read from current pointer; optional command + repeated START first
  task automatic do_read(input logic [6:0] a, input logic use_cmd,
                         input logic [7:0] cmd, input int n);
    logic ack; logic [7:0] b; int r0;
    bus_start();
    if (use_cmd) begin
      wbyte({a, 1'b0}, ack); chk("R2 address ack", ack, 1);
      wbyte(cmd, ack);       chk("R4 command ack", ack, 1);
      exp_ptr = cmd[3:0];
      bus_start();
    end
    r0 = rn;
    wbyte({a, 1'b1}, ack); chk("R2 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(k == n - 1, b);
      chk("R6 read byte", b, regs[exp_ptr]);
      chk("R6 read addr", ra[(r0 + k) % 64], exp_ptr);
      exp_ptr = exp_ptr + 4'd1;
    end
    q();
    chk("R7 released after nack", sda_oe, 0);
    bus_stop(); q();
    chk("R7 no extra read request", rn - r0, n);
  endtask

  // Foreign address: nothing acknowledged, no strobes
  task automatic do_foreign(input logic [6:0] a, input logic rd);
    logic ack; int w0, r0;
    w0 = wn; r0 = rn;
    bus_start();
    wbyte({a, rd}, ack); chk("R3 foreign address nack", ack, 0);
    wbyte(8'h03, ack);   chk("R3 later byte nack", ack, 0);
    wbyte(8'hA5, ack);   chk("R3 later byte nack", ack, 0);
    bus_stop(); q();
    chk("R3 no writes", wn - w0, 0);
    chk("R3 no reads", rn - r0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int seed;
    logic ack; int w0;
    seed = 32'h1A2B;
    void'($urandom(seed));
    for (int i = 0; i < 16; i++) regs[i] = 8'($urandom);
    repeat (5) @(negedge clk);
    chk("R11 sda_oe reset", sda_oe, 0);
    chk("R11 int_oe reset", int_oe, 0);
    chk("R11 wr strobe reset", reg_wr_en, 0);
    chk("R11 rd strobe reset", rd_req, 0);
    rst = 1'b0; q();

    // R11: pointer starts at 0 (receive-byte form)
    do_read(addr_of(2'b00), 1'b0, 8'h00, 1);

    // R1: each strap code gives its address; send-byte form
    for (int c = 0; c < 4; c++) begin
      strap = 2'(c); q();
      bus_start(); wbyte({addr_of(2'(c)), 1'b0}, ack);
      chk("R1 strap address ack", ack, 1);
      wbyte(8'h05, ack); chk("R4 send-byte command ack", ack, 1);
      exp_ptr = 4'd5; bus_stop(); q();
      do_foreign(addr_of(2'(c)) ^ 7'h10, 1'b0);
    end
    strap = 2'b10; q();
    do_read(addr_of(2'b10), 1'b0, 8'h00, 1); // R4 pointer from send-byte

    // R4/R5: upper command bits ignored, pointer wraps 14,15,0,1
    do_write(addr_of(2'b10), 8'hFE, 4);
    // R6: burst read crossing wrap through repeated START
    do_read(addr_of(2'b10), 1'b1, 8'h7E, 4);
    // R3: foreign read address
    do_foreign(7'h2A, 1'b1);

    // R9: repeated START in the middle of a write restarts address phase
    w0 = wn;
    bus_start(); wbyte({addr_of(2'b10), 1'b0}, ack); wbyte(8'h03, ack);
    wbyte(8'h5C, ack);
    bus_start(); wbyte({addr_of(2'b10), 1'b0}, ack);
    chk("R9 address after repeated start", ack, 1);
    wbyte(8'h09, ack); wbyte(8'hC3, ack); bus_stop(); q();
    chk("R9 write count", wn - w0, 2);
    chk("R9 second write addr", wa[(w0 + 1) % 64], 9);
    chk("R9 second write data", wd[(w0 + 1) % 64], 8'hC3);
    exp_ptr = 4'd10;

    // R10: interrupt pin follows source
    irq = 1'b1; @(negedge clk); @(negedge clk);
    chk("R10 int asserted", int_oe, 1);
    irq = 1'b0; @(negedge clk); @(negedge clk);
    chk("R10 int released", int_oe, 0);

    // Constrained random traffic
    for (int it = 0; it < 30; it++) begin
      int kind, n;
      strap = 2'($urandom_range(0, 3)); q();
      kind = $urandom_range(0, 3);
      n = $urandom_range(1, 3);
      case (kind)
        0: do_write(addr_of(strap), 8'($urandom), n);
        1: do_read(addr_of(strap), 1'b1, 8'($urandom), n);
        2: do_read(addr_of(strap), 1'b0, 8'h00, n);
        default: do_foreign(addr_of(strap) ^ 7'(1 << $urandom_range(0, 6)),
                            1'($urandom));
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule